// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of two-bit saturating counters. A table entry is chosen by XOR-ing the word-aligned bits of the branch address with a register that records the most recent branch outcomes across the whole program. A fetch unit presents an address on the lookup port and gets a taken/not-taken guess back in the same cycle. It also gets a copy of the history that was used for that guess.

The fetch unit carries that history value along with the branch. When the branch resolves, the resolved address, the real outcome and the carried history are presented on the training port. The block then moves the selected counter one step toward the outcome and shifts the outcome into the live history. Entries carry no tags, so two branches that map to the same entry share its counter. The table depth and the history length are parameters, and the history must be no longer than the index.

Top module: `gshare_dir_pred`

## Requirements
- R1: A counter value of 2 or 3 makes `guess_taken` high, and a value of 0 or 1 makes it low. Counter encoding: 0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken.
- R2: A training event with `train_taken`=1 increments the selected counter by one, and one with `train_taken`=0 decrements it by one, unless the counter is at a limit.
- R3: Counters saturate: a taken training at 3 leaves the counter at 3, and a not-taken training at 0 leaves it at 0.
- R4: From a strong state, two consecutive mispredicting trainings are needed before the guess flips. After one, the guess is unchanged.
- R5: While `rst_n` is low at a clock edge, every counter becomes 1 (weak not-taken) and the history becomes 0. After reset every lookup returns not-taken and `guess_hist` reads 0.
- R6: The lookup entry is `look_pc[IDX_W+1:2]` XOR the live history, with the history zero-extended to IDX_W bits. Bits `look_pc[1:0]` and all bits above IDX_W+1 have no effect.
- R7: Each training event shifts the history left by one, puts `train_taken` in bit 0 and drops the oldest bit. `guess_hist` shows the live history.
- R8: The training entry is `train_pc[IDX_W+1:2]` XOR `train_hist`, not XOR the live history.
- R9: With `train_valid` low, no counter and no history bit changes, whatever the other training inputs do.
- R10: A lookup that hits the entry being trained in the same cycle returns the counter value from before that training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| look_pc | input | PC_W | Address of the instruction being fetched |
| guess_taken | output | 1 | Taken guess for `look_pc`, combinational |
| guess_hist | output | HIST_W | Live history, to be carried with the branch |
| train_valid | input | 1 | Training event this cycle |
| train_pc | input | PC_W | Address of the resolved branch |
| train_taken | input | 1 | Real outcome, 1 = taken |
| train_hist | input | HIST_W | History value captured at lookup time |

## Verification
On every cycle the assertions check the history behaviour: it holds with no training event, and a training event puts the outcome in bit 0. They also check that the table holds when idle and that the trained counter stays pinned at either limit. The remaining behaviours can only be shown by the bench's scenarios: the guess threshold, the two-miss hysteresis, the hashed index with its ignored address bits, training through the carried history instead of the live one, and the read-before-write result on a shared entry. The bench covers them by comparing every lookup against an arithmetic model of the table. This includes full sweeps of all entries after reset, after directed training, and after a long pseudo-random training run.

// File: rtl/gdp_pkg.sv
// Package gdp_pkg
// Shared counter encoding and the saturating step for the direction predictor.
// Assumes two-bit counters; the MSB of a counter is the taken guess.
package gdp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_e;

    // Move a counter one step toward the outcome, pinned at both ends.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        nxt = cur;
        if (taken && (cur != CTR_STRONG_T)) begin
            nxt = cur + 2'd1;
        end else if (!taken && (cur != CTR_STRONG_NT)) begin
            nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/gdp_hist_reg.sv
// Module gdp_hist_reg
// Global outcome history: a shift register that takes each training outcome
// into bit 0. Assumes at most one training event per cycle.
module gdp_hist_reg #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W:0] widened;

    // Widen by one bit so the shift also works for a one-bit history.
    always_comb begin
        widened = {hist, shift_bit};
    end

    // Clear on reset, shift in the outcome on a training event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= widened[HIST_W-1:0];
        end
    end

    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist));

    assert_hist_newest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist[0] == $past(shift_bit)));

endmodule

// File: rtl/gdp_ctr_table.sv
// Module gdp_ctr_table
// Untagged table of two-bit saturating counters: one combinational read port
// and one write port that trains a single entry per cycle. A read of the
// entry being written returns the old value. Assumes both indices are in range.
module gdp_ctr_table #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    import gdp_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][1:0] tbl;

    // Read port: the current stored counter.
    always_comb begin
        rd_ctr = tbl[rd_idx];
    end

    // Reset all entries to weak not-taken, otherwise train one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= CTR_WEAK_NT;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
        end
    end

    assert_tbl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tbl));

    assert_sat_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && (tbl[wr_idx] == 2'd3)) |=> (tbl[$past(wr_idx)] == 2'd3));

    assert_sat_bottom_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && (tbl[wr_idx] == 2'd0)) |=> (tbl[$past(wr_idx)] == 2'd0));

endmodule

// File: rtl/gshare_dir_pred.sv
// Module gshare_dir_pred
// Branch direction predictor. The lookup entry is the word-aligned PC bits XOR
// the global history. Training uses the history carried from lookup time.
// Assumes HIST_W <= IDX_W and PC_W >= IDX_W + 2.
module gshare_dir_pred #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   look_pc,
    output logic              guess_taken,
    output logic [HIST_W-1:0] guess_hist,
    input  logic              train_valid,
    input  logic [PC_W-1:0]   train_pc,
    input  logic              train_taken,
    input  logic [HIST_W-1:0] train_hist
);

    localparam int LO = 2;
    localparam int HI = IDX_W + LO - 1;

    logic [HIST_W-1:0] live_hist;
    logic [IDX_W-1:0]  look_idx;
    logic [IDX_W-1:0]  train_idx;
    logic [1:0]        look_ctr;
    logic              unused_pc_bits;

    // Hash both addresses with their history values into table indices.
    always_comb begin
        look_idx  = look_pc[HI:LO] ^ IDX_W'(live_hist);
        train_idx = train_pc[HI:LO] ^ IDX_W'(train_hist);
    end

    // Address bits that take no part in the index.
    always_comb begin
        unused_pc_bits = ^{look_pc[1:0], train_pc[1:0]};
    end

    gdp_hist_reg #(.HIST_W(HIST_W)) hist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (train_valid),
        .shift_bit (train_taken),
        .hist      (live_hist)
    );

    gdp_ctr_table #(.IDX_W(IDX_W)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_idx),
        .rd_ctr   (look_ctr),
        .wr_en    (train_valid),
        .wr_idx   (train_idx),
        .wr_taken (train_taken)
    );

    // Guess is the counter MSB; expose the live history for carrying.
    always_comb begin
        guess_taken = look_ctr[1];
        guess_hist  = live_hist;
    end

    assert_hist_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !train_valid |=> $stable(guess_hist));

endmodule

// File: tb/gshare_dir_pred_tb_top.sv
`timescale 1ns/100ps
module gshare_dir_pred_tb_top;

    localparam int PC_W   = 32;
    localparam int IDX_W  = 8;
    localparam int HIST_W = 8;
    localparam int DEPTH  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   look_pc = '0;
    logic              guess_taken;
    logic [HIST_W-1:0] guess_hist;
    logic              train_valid = 1'b0;
    logic [PC_W-1:0]   train_pc = '0;
    logic              train_taken = 1'b0;
    logic [HIST_W-1:0] train_hist = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int mc [DEPTH];
    logic [HIST_W-1:0] mh;
    logic [31:0] rng = 32'h1234_5679;

    always #2 clk = ~clk;

    gshare_dir_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .look_pc(look_pc), .guess_taken(guess_taken),
        .guess_hist(guess_hist), .train_valid(train_valid), .train_pc(train_pc),
        .train_taken(train_taken), .train_hist(train_hist)
    );

    function automatic int idx_of(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
        return int'(pc[IDX_W+1:2] ^ IDX_W'(h));
    endfunction

    function automatic logic [PC_W-1:0] pc_for(input int e, input logic [HIST_W-1:0] h);
        logic [IDX_W-1:0] b;
        b = IDX_W'(e) ^ IDX_W'(h);
        return PC_W'({b, 2'b00});
    endfunction

    function automatic logic [31:0] nxt_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        return x ^ (x << 5);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare before the rising edge, then advance the model.
    task automatic step(input bit uv, input logic [PC_W-1:0] upc, input bit ut,
                        input logic [HIST_W-1:0] uh, input logic [PC_W-1:0] ppc, input string tag);
        int pi;
        int ui;
        bit ex;
        @(negedge clk);
        train_valid = uv; train_pc = upc; train_taken = ut; train_hist = uh; look_pc = ppc;
        #1;
        pi = idx_of(ppc, mh);
        ex = (mc[pi] >= 2);
        chk(guess_taken == ex, tag, int'(guess_taken), int'(ex));
        chk(guess_hist == mh, "R7 history output", int'(guess_hist), int'(mh));
        @(posedge clk);
        if (uv) begin
            ui = idx_of(upc, uh);
            if (ut && mc[ui] < 3) mc[ui]++;
            else if (!ut && mc[ui] > 0) mc[ui]--;
            mh = {mh[HIST_W-2:0], ut};
        end
    endtask

    task automatic train(input int e, input bit t, input string tag);
        step(1'b1, pc_for(e, mh), t, mh, pc_for(e, mh), tag);
    endtask

    task automatic probe(input int e, input string tag);
        step(1'b0, '0, 1'b0, '0, pc_for(e, mh), tag);
    endtask

    task automatic sweep(input string tag);
        for (int e = 0; e < DEPTH; e++) probe(e, tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mc[i] = 1;
        mh = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R5: reset state, every entry weak not-taken and history zero
        sweep("R5 reset entry");
        // R1 R2: one taken training lifts entry 0x40 to weak taken
        train(8'h40, 1'b1, "R10 old value during training");
        probe(8'h40, "R1 R2 guess after increment");
        chk(mc[8'h40] == 2 && guess_taken == 1'b1, "R1 weak taken guesses taken", int'(guess_taken), 1);
        train(8'h40, 1'b1, "R2 increment");
        train(8'h40, 1'b1, "R3 at top");
        probe(8'h40, "R3 saturated top");
        // R4: first miss from strong keeps the guess, second flips it
        train(8'h40, 1'b0, "R4 first miss");
        probe(8'h40, "R4 guess kept");
        chk(guess_taken == 1'b1, "R4 one miss does not flip", int'(guess_taken), 1);
        train(8'h40, 1'b0, "R4 second miss");
        probe(8'h40, "R4 guess flipped");
        chk(guess_taken == 1'b0, "R4 two misses flip", int'(guess_taken), 0);
        train(8'h40, 1'b0, "R2 decrement");
        train(8'h40, 1'b0, "R3 at bottom");
        probe(8'h40, "R3 saturated bottom");
        // R6: low and high address bits do not matter
        train(8'h11, 1'b1, "R6 train");
        step(1'b0, '0, 1'b0, '0, pc_for(8'h11, mh) | 32'hABCD_0003, "R6 ignored pc bits");
        chk(guess_taken == 1'b1, "R6 hashed entry hit", int'(guess_taken), 1);
        // R8: training indexes through the carried history, not the live one
        step(1'b1, pc_for(8'h22, ~mh), 1'b1, ~mh, '0, "R8 train carried hist");
        step(1'b1, pc_for(8'h22, 8'h5A), 1'b1, 8'h5A, '0, "R8 train carried hist");
        probe(8'h22, "R8 entry via carried hist");
        chk(mc[8'h22] == 3, "R8 model entry", mc[8'h22], 3);
        // R9: idle training inputs with valid low change nothing
        for (int k = 0; k < 20; k++) begin
            rng = nxt_rng(rng);
            step(1'b0, rng, rng[5], rng[15:8], pc_for(8'h22, mh), "R9 idle");
        end
        sweep("R9 table unchanged");
        // R10: same-entry read during training returns old count
        train(8'h77, 1'b1, "R10 read before write");
        // R2 R3 R7 R8: long pseudo-random training, carried history sometimes stale
        for (int k = 0; k < 3000; k++) begin
            logic [HIST_W-1:0] uh;
            rng = nxt_rng(rng);
            uh = rng[28] ? mh : rng[27:20];
            step(rng[0] | rng[1], {rng[31:12], rng[11:0]}, rng[2] ^ rng[9], uh,
                 nxt_rng(rng), "R2 random training");
        end
        sweep("R2 R3 table after random run");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule